// File: doc/BRIEF.md
# Four-Digit BCD Shift Register with Split Control

A register of four 4-bit decimal digits, numbered D3 (most significant) down to D0 (least significant). It can hold its contents, move every digit one position up or down, or zero itself. It sits in a digit-serial decimal datapath.

Digits enter at the bottom on an upward move and at the top on a downward move. All four digits are visible in parallel at the output, so a display or an adjacent stage can read them directly.

The bottom digit position has its own 2-bit control code. The three upper positions share a second code. This split allows a single-cycle "start a new number" operation: the first keyed digit is written into D0 while D3 through D1 are zeroed. The contents are not checked for valid decimal values.

Top module: `bcd_shift4`

## Requirements
- R1: When `rst` is high at a rising clock edge, all four digits become 0.
- R2: A position whose control code is 2'b00 keeps its digit unchanged across the edge.
- R3: Code 2'b10 moves digits upward. D0 takes `left_in`, and each Dn (n = 1..3) takes the old D(n-1). The old D3 is discarded.
- R4: Code 2'b01 moves digits downward. D3 takes `right_in`, and each Dn (n = 0..2) takes the old D(n+1). The old D0 is discarded.
- R5: A position whose control code is 2'b11 becomes 0.
- R6: `lo_ctl` governs only D0, and `hi_ctl` governs only D3..D1. Outputs pack Dn at `digits_o[4n+3:4n]`.
- R7: With `lo_ctl` = 2'b10 and `hi_ctl` = 2'b11, D0 becomes `left_in` and D3..D1 become 0 in the same cycle.
- R8: When the two codes differ, each position follows its own code. A moving position takes its neighbour's value from before the edge.
- R9: Reset takes priority over any control codes applied in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lo_ctl | input | 2 | Control code for position D0 |
| hi_ctl | input | 2 | Control code for positions D3..D1 |
| left_in | input | 4 | Digit entering D0 on an upward move |
| right_in | input | 4 | Digit entering D3 on a downward move |
| digits_o | output | 16 | All four digits, Dn at bits 4n+3:4n |

## Verification
The bench pays most attention to the boundary between D0 and D1 when the two codes differ.

- If a design routed `lo_ctl` to every position, the combined load-and-clear would leave stale upper digits.
- If a design read a neighbour's already-updated value, a mixed move such as D0 moving down while the upper digits hold would copy the wrong digit.
- The ends of the register are exercised with different digits on `left_in` and `right_in`. A swapped or missing end input shows up as a 7 where an 8 belongs.
- Reset is asserted together with non-hold codes to show that it wins.

// File: rtl/bcd_shift4_pkg.sv
package bcd_shift4_pkg;

    typedef enum logic [1:0] {
        CTL_HOLD = 2'b00,
        CTL_DOWN = 2'b01,
        CTL_UP   = 2'b10,
        CTL_ZERO = 2'b11
    } ctl_e;

    // Next value of one digit position given its code and both neighbours.
    function automatic logic [3:0] next_digit(input ctl_e code,
                                              input logic [3:0] cur,
                                              input logic [3:0] below,
                                              input logic [3:0] above);
        logic [3:0] r;
        unique case (code)
            CTL_HOLD: r = cur;
            CTL_DOWN: r = above;
            CTL_UP:   r = below;
            default:  r = 4'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcd_shift4_route.sv
module bcd_shift4_route
    import bcd_shift4_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic [1:0]            lo_ctl,
    input  logic [1:0]            hi_ctl,
    output logic [NDIG-1:0][1:0]  pos_ctl
);
    // Position 0 follows the low code, every other position the high code.
    for (genvar g = 0; g < NDIG; g++) begin : g_route
        if (g == 0) begin : g_low
            assign pos_ctl[g] = lo_ctl;
        end else begin : g_high
            assign pos_ctl[g] = hi_ctl;
        end
    end
endmodule

// File: rtl/bcd_shift4_cell.sv
module bcd_shift4_cell
    import bcd_shift4_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    ctl,
    input  logic [DW-1:0] below,
    input  logic [DW-1:0] above,
    output logic [DW-1:0] q
);
    ctl_e code;
    assign code = ctl_e'(ctl);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= next_digit(code, q, below, above);
    end

    a_r1_reset_zero: assert property (@(posedge clk) rst |=> q == '0);
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
        code == CTL_HOLD |=> $stable(q));
    a_r3_up_takes_below: assert property (@(posedge clk) disable iff (rst)
        code == CTL_UP |=> q == $past(below));
    a_r4_down_takes_above: assert property (@(posedge clk) disable iff (rst)
        code == CTL_DOWN |=> q == $past(above));
    a_r5_zero: assert property (@(posedge clk) disable iff (rst)
        code == CTL_ZERO |=> q == '0);
endmodule

// File: rtl/bcd_shift4.sv
module bcd_shift4
    import bcd_shift4_pkg::*;
#(
    parameter int NDIG = 4,
    parameter int DW   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           lo_ctl,
    input  logic [1:0]           hi_ctl,
    input  logic [DW-1:0]        left_in,
    input  logic [DW-1:0]        right_in,
    output logic [NDIG*DW-1:0]   digits_o
);
    localparam int TW = NDIG * DW;

    logic [NDIG-1:0][1:0]   pos_ctl;
    logic [NDIG-1:0][DW-1:0] dq;

    bcd_shift4_route #(.NDIG(NDIG)) route_i (
        .lo_ctl (lo_ctl),
        .hi_ctl (hi_ctl),
        .pos_ctl(pos_ctl)
    );

    for (genvar g = 0; g < NDIG; g++) begin : g_pos
        logic [DW-1:0] from_below, from_above;
        if (g == 0) begin : g_bot
            assign from_below = left_in;
        end else begin : g_bot
            assign from_below = dq[g-1];
        end
        if (g == NDIG-1) begin : g_top
            assign from_above = right_in;
        end else begin : g_top
            assign from_above = dq[g+1];
        end
        bcd_shift4_cell #(.DW(DW)) cell_i (
            .clk  (clk),
            .rst  (rst),
            .ctl  (pos_ctl[g]),
            .below(from_below),
            .above(from_above),
            .q    (dq[g])
        );
    end

    assign digits_o = TW'(dq);

    // R7: combined first-digit load with upper clear
    a_r7_load_first: assert property (@(posedge clk) disable iff (rst)
        (lo_ctl == CTL_UP && hi_ctl == CTL_ZERO) |=>
        (digits_o[DW-1:0] == $past(left_in) && digits_o[TW-1:DW] == '0));
    // R6: upper positions ignore the low code when the high code holds
    a_r6_upper_split: assert property (@(posedge clk) disable iff (rst)
        hi_ctl == CTL_HOLD |=> $stable(digits_o[TW-1:DW]));
endmodule

// File: tb/bcd_shift4_tb_top.sv
module bcd_shift4_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  lo_ctl, hi_ctl;
    logic [3:0]  left_in, right_in;
    logic [15:0] digits_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] m [4];

    bcd_shift4 dut_i (
        .clk(clk), .rst(rst), .lo_ctl(lo_ctl), .hi_ctl(hi_ctl),
        .left_in(left_in), .right_in(right_in), .digits_o(digits_o)
    );

    always #4 clk = ~clk;

    function automatic logic [3:0] nd(input logic [1:0] c, input logic [3:0] cur,
                                      input logic [3:0] lo, input logic [3:0] hi);
        case (c)
            2'b00: return cur;
            2'b01: return hi;
            2'b10: return lo;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [15:0] packm();
        return {m[3], m[2], m[1], m[0]};
    endfunction

    task automatic model_step(input logic r, input logic [1:0] lc, input logic [1:0] hc,
                              input logic [3:0] li, input logic [3:0] ri);
        logic [3:0] o [4];
        o = m;
        if (r) begin
            for (int i = 0; i < 4; i++) m[i] = 4'd0;
        end else begin
            m[0] = nd(lc, o[0], li, o[1]);
            m[1] = nd(hc, o[1], o[0], o[2]);
            m[2] = nd(hc, o[2], o[1], o[3]);
            m[3] = nd(hc, o[3], o[2], ri);
        end
    endtask

    // Drive at falling edge, clock once, compare at next falling edge.
    task automatic step(input logic r, input logic [1:0] lc, input logic [1:0] hc,
                        input logic [3:0] li, input logic [3:0] ri, input string tag);
        rst = r; lo_ctl = lc; hi_ctl = hc; left_in = li; right_in = ri;
        model_step(r, lc, hc, li, ri);
        @(negedge clk);
        n_tests++;
        if (digits_o !== packm()) begin
            n_fail++;
            $display("FAIL %s: digits actual %h expected %h", tag, digits_o, packm());
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [1:0] lc, hc;
        string tg;
        for (int i = 0; i < 4; i++) m[i] = 4'd0;
        rst = 1'b1; lo_ctl = 2'b00; hi_ctl = 2'b00; left_in = 4'd0; right_in = 4'd0;
        @(negedge clk);
        step(1'b1, 2'b00, 2'b00, 4'd0, 4'd0, "R1 reset");
        // R4: four downward moves of 7
        for (int i = 0; i < 4; i++) step(1'b0, 2'b01, 2'b01, 4'd0, 4'd7, "R4 down 7");
        step(1'b0, 2'b00, 2'b00, 4'd5, 4'd5, "R2 hold");
        step(1'b0, 2'b11, 2'b11, 4'd5, 4'd5, "R5 clear");
        // R3: four upward moves of 7
        for (int i = 0; i < 4; i++) step(1'b0, 2'b10, 2'b10, 4'd7, 4'd0, "R3 up 7");
        for (int i = 0; i < 4; i++) step(1'b0, 2'b01, 2'b01, 4'd0, 4'd8, "R4 down 8");
        step(1'b0, 2'b00, 2'b00, 4'd0, 4'd0, "R2 hold");
        for (int i = 0; i < 4; i++) step(1'b0, 2'b01, 2'b01, 4'd8, 4'd7, "R4 down 7 ends");
        for (int i = 0; i < 4; i++) step(1'b0, 2'b10, 2'b10, 4'd8, 4'd7, "R3 up 8 ends");
        step(1'b0, 2'b10, 2'b00, 4'd3, 4'd9, "R6 low only");
        step(1'b0, 2'b00, 2'b11, 4'd3, 4'd9, "R6 high only");
        step(1'b0, 2'b10, 2'b10, 4'd4, 4'd0, "R3 up");
        step(1'b0, 2'b10, 2'b10, 4'd6, 4'd0, "R3 up");
        step(1'b0, 2'b10, 2'b11, 4'd2, 4'd9, "R7 load first");
        step(1'b0, 2'b10, 2'b10, 4'd5, 4'd0, "R3 up");
        step(1'b0, 2'b01, 2'b00, 4'd0, 4'd9, "R8 low down high hold");
        step(1'b0, 2'b00, 2'b10, 4'd0, 4'd9, "R8 low hold high up");
        step(1'b0, 2'b01, 2'b10, 4'd1, 4'd9, "R8 swap");
        step(1'b1, 2'b10, 2'b01, 4'd7, 4'd7, "R9 reset wins");
        step(1'b0, 2'b10, 2'b11, 4'd9, 4'd1, "R7 load first");
        seed = 32'd1352;
        void'($urandom(seed));
        for (int i = 0; i < 400; i++) begin
            lc = 2'($urandom_range(3));
            hc = ($urandom_range(3) == 0) ? 2'($urandom_range(3)) : lc;
            if (lc == 2'b10 && hc == 2'b11) tg = "R7 rand";
            else if (lc != hc) tg = "R8 rand";
            else if (lc == 2'b00) tg = "R2 rand";
            else if (lc == 2'b01) tg = "R4 rand";
            else if (lc == 2'b10) tg = "R3 rand";
            else tg = "R5 rand";
            step(($urandom_range(49) == 0), lc, hc, 4'($urandom_range(9)),
                 4'($urandom_range(9)), ($urandom_range(49) == 0) ? "R9 rand" : tg);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule